// File: doc/BRIEF.md
# Double-Buffered Bulk IN Transmit Buffer

This block is the transmit data store for a single bulk IN endpoint of a USB device. It holds two banks of `BANK_BYTES` bytes (64 by default), used strictly in alternation. A DMA controller fills the bank currently open for writing, one byte per cycle, through a simple valid/data port. The block asks for data with a level request. That request stays high whenever the DMA-enable input is set and the open bank still has room. The block raises it whether or not the application has anything left to send.

A bank is handed to the USB side ("committed") in one of two ways. The first is automatic: the write that brings the bank to its full size commits it. The second is a software packet-enable strobe, used for a final packet shorter than a full bank. A strobe on an empty bank commits a zero-length packet. A strobe that finds the open bank already committed is ignored. So is a strobe in the same cycle as the filling write. After each commit, writing moves to the other bank.

The USB engine sees the oldest committed bank. It gets its byte count and the byte at the read position. It steps through the bytes with a read strobe, and it frees the bank with a packet-sent strobe. A synchronous clear input empties the whole block at once.

Top module: `usb_in_pingpong_fifo`

## Requirements
- R1: After reset, `pkt_avail` and `wr_full` are 0, and `dma_req` equals `dma_en`.
- R2: The write that brings the open bank to `BANK_BYTES` bytes commits it. The bank is then reported with `pkt_len` equal to `BANK_BYTES`, and writing continues in the other bank.
- R3: A bank holding fewer than `BANK_BYTES` bytes is not offered to the USB side until `pkt_en` is strobed. It is then offered with `pkt_len` equal to the bytes written.
- R4: A `pkt_en` strobe while the open bank holds no bytes commits a packet with `pkt_len` 0.
- R5: A `pkt_en` strobe is ignored while the open bank is committed, and also in the cycle of the write that fills the bank. Neither case produces an extra packet.
- R6: While `dma_en` is 1 and the open bank is uncommitted, `dma_req` stays 1 on every cycle, even when no writes arrive.
- R7: While `dma_en` is 0, `dma_req` is 0.
- R8: When both banks are committed, `wr_full` is 1 and `dma_req` is 0. Bytes presented on the write port in that state are discarded.
- R9: `pkt_avail` and `pkt_len` describe the oldest committed bank. `rd_data` shows its bytes in written order, and each `rd_en` advances one byte. Packets reach the USB side in commit order.
- R10: `pkt_sent` while `pkt_avail` is 1 frees the oldest bank, so the next packet (or none) is shown from the next cycle. `pkt_sent` while `pkt_avail` is 0 has no effect.
- R11: `fifo_clr` empties both banks and drops any uncommitted bytes. From the next cycle `pkt_avail` and `wr_full` are 0, and new writes start a fresh packet.
- R12: A 150-byte transfer becomes two automatic 64-byte packets and one 22-byte packet, and the last one is committed by a single `pkt_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_clr | input | 1 | Synchronous clear of both banks and pointers |
| dma_en | input | 1 | DMA-enable control bit |
| dma_req | output | 1 | DMA transfer request (level) |
| dma_wr_valid | input | 1 | Write strobe from the DMA controller |
| dma_wr_data | input | DATA_W | Write byte |
| pkt_en | input | 1 | Software packet-enable strobe (short packet commit) |
| wr_full | output | 1 | Both banks committed, no write space |
| pkt_avail | output | 1 | A committed packet is waiting |
| pkt_len | output | $clog2(BANK_BYTES+1) | Byte count of the oldest committed packet |
| rd_en | input | 1 | Advance to the next byte of the packet |
| rd_data | output | DATA_W | Byte at the current read position |
| pkt_sent | input | 1 | Packet transmitted, free the oldest bank |

## Verification
Two situations are hard to reach from the ports. One is a packet-enable strobe that finds the open bank already committed. That needs both banks full with nothing drained, so the bench writes 128 bytes before reading anything, strobes `pkt_en`, and pushes one more byte. It then drains both packets. Only after that does a final strobe show, through a zero-length packet, that neither the stray strobe nor the stray byte left a trace. The other is a strobe in the same cycle as the 64th write. The bench raises `pkt_en` together with that write, then checks that freeing the resulting packet leaves nothing available.

// File: rtl/usbtx_pkg.sv
package usbtx_pkg;

    localparam int unsigned NUM_BANKS = 2;

    typedef enum logic {
        BANK_A = 1'b0,
        BANK_B = 1'b1
    } bank_id_t;

    typedef enum logic [1:0] {
        CMT_NONE = 2'd0,
        CMT_AUTO = 2'd1,
        CMT_SOFT = 2'd2
    } commit_src_t;

    function automatic bank_id_t other_bank(input bank_id_t b);
        return (b == BANK_A) ? BANK_B : BANK_A;
    endfunction

endpackage

// File: rtl/usbtx_bank_ram.sv
module usbtx_bank_ram
    import usbtx_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 64,
    localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  bank_id_t          wr_bank,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  bank_id_t          rd_bank,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [NUM_BANKS-1:0][DATA_W-1:0] bank_q;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic [DATA_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && (int'(wr_bank) == g)) begin
                mem[wr_addr] <= wr_data;
            end
        end

        assign bank_q[g] = mem[rd_addr];
    end

    assign rd_data = bank_q[rd_bank];

endmodule

// File: rtl/usbtx_wr_ctrl.sv
module usbtx_wr_ctrl
    import usbtx_pkg::*;
#(
    parameter int unsigned BANK_BYTES = 64,
    localparam int unsigned CNT_W = $clog2(BANK_BYTES + 1)
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             clr,
    input  logic                             wr_valid,
    input  logic                             pkt_en,
    input  logic                             free_req,
    input  bank_id_t                         free_bank,
    output logic                             wr_fire,
    output bank_id_t                         wr_bank,
    output logic [CNT_W-1:0]                 wr_fill,
    output logic [NUM_BANKS-1:0]             committed,
    output logic [NUM_BANKS-1:0][CNT_W-1:0]  fill
);

    localparam logic [CNT_W-1:0] LAST_FILL = CNT_W'(BANK_BYTES - 1);

    commit_src_t cmt_src;

    always_comb begin
        wr_fill = fill[wr_bank];
        wr_fire = wr_valid && !committed[wr_bank] && !clr;
        cmt_src = CMT_NONE;
        if (wr_fire && (wr_fill == LAST_FILL)) begin
            cmt_src = CMT_AUTO;
        end else if (pkt_en && !committed[wr_bank] && !clr) begin
            cmt_src = CMT_SOFT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            committed <= '0;
            fill      <= '0;
            wr_bank   <= BANK_A;
        end else begin
            if (free_req) begin
                committed[free_bank] <= 1'b0;
                fill[free_bank]      <= '0;
            end
            if (wr_fire) begin
                fill[wr_bank] <= wr_fill + 1'b1;
            end
            if (cmt_src != CMT_NONE) begin
                committed[wr_bank] <= 1'b1;
                wr_bank            <= other_bank(wr_bank);
            end
        end
    end

    // R2: the filling write leaves its bank committed
    a_r2_auto_commit: assert property (@(posedge clk) disable iff (rst)
        (wr_fire && (wr_fill == LAST_FILL)) |=> committed[$past(wr_bank)]);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
        // R3: a bank becomes committed only by a strobe or by its last byte
        a_r3_commit_cause: assert property (@(posedge clk) disable iff (rst)
            $rose(committed[b]) |-> ($past(pkt_en) || ($past(fill[b]) == LAST_FILL)));
        // R2: an open bank never sits full without being committed
        a_r2_open_not_full: assert property (@(posedge clk) disable iff (rst)
            !committed[b] |-> (fill[b] < CNT_W'(BANK_BYTES)));
    end

    // R11: clear leaves nothing committed
    a_r11_clear_empties: assert property (@(posedge clk) disable iff (rst)
        clr |=> (committed == '0));

endmodule

// File: rtl/usbtx_rd_ctrl.sv
module usbtx_rd_ctrl
    import usbtx_pkg::*;
#(
    parameter int unsigned BANK_BYTES = 64,
    localparam int unsigned CNT_W = $clog2(BANK_BYTES + 1)
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             clr,
    input  logic                             rd_en,
    input  logic                             pkt_sent,
    input  logic [NUM_BANKS-1:0]             committed,
    input  logic [NUM_BANKS-1:0][CNT_W-1:0]  fill,
    output bank_id_t                         rd_bank,
    output logic [CNT_W-1:0]                 rd_ptr,
    output logic                             pkt_avail,
    output logic [CNT_W-1:0]                 pkt_len,
    output logic                             free_req
);

    always_comb begin
        pkt_avail = committed[rd_bank];
        pkt_len   = fill[rd_bank];
        free_req  = pkt_sent && pkt_avail && !clr;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            rd_bank <= BANK_A;
            rd_ptr  <= '0;
        end else if (free_req) begin
            rd_bank <= other_bank(rd_bank);
            rd_ptr  <= '0;
        end else if (rd_en && pkt_avail && (rd_ptr < pkt_len)) begin
            rd_ptr <= rd_ptr + 1'b1;
        end
    end

    // R9: the read position never passes the committed length
    a_r9_ptr_bound: assert property (@(posedge clk) disable iff (rst)
        pkt_avail |-> (rd_ptr <= pkt_len));

    // R10: freeing a packet moves reading to the other bank
    a_r10_free_advances: assert property (@(posedge clk) disable iff (rst)
        free_req |=> (rd_bank != $past(rd_bank)));

endmodule

// File: rtl/usb_in_pingpong_fifo.sv
module usb_in_pingpong_fifo
    import usbtx_pkg::*;
#(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned BANK_BYTES = 64,
    localparam int unsigned CNT_W  = $clog2(BANK_BYTES + 1),
    localparam int unsigned ADDR_W = $clog2(BANK_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fifo_clr,
    input  logic              dma_en,
    output logic              dma_req,
    input  logic              dma_wr_valid,
    input  logic [DATA_W-1:0] dma_wr_data,
    input  logic              pkt_en,
    output logic              wr_full,
    output logic              pkt_avail,
    output logic [CNT_W-1:0]  pkt_len,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              pkt_sent
);

    logic                            wr_fire;
    bank_id_t                        wr_bank;
    logic [CNT_W-1:0]                wr_fill;
    logic [NUM_BANKS-1:0]            committed;
    logic [NUM_BANKS-1:0][CNT_W-1:0] fill;
    bank_id_t                        rd_bank;
    logic [CNT_W-1:0]                rd_ptr;
    logic                            free_req;

    usbtx_wr_ctrl #(.BANK_BYTES(BANK_BYTES)) wr_ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .clr       (fifo_clr),
        .wr_valid  (dma_wr_valid),
        .pkt_en    (pkt_en),
        .free_req  (free_req),
        .free_bank (rd_bank),
        .wr_fire   (wr_fire),
        .wr_bank   (wr_bank),
        .wr_fill   (wr_fill),
        .committed (committed),
        .fill      (fill)
    );

    usbtx_rd_ctrl #(.BANK_BYTES(BANK_BYTES)) rd_ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .clr       (fifo_clr),
        .rd_en     (rd_en),
        .pkt_sent  (pkt_sent),
        .committed (committed),
        .fill      (fill),
        .rd_bank   (rd_bank),
        .rd_ptr    (rd_ptr),
        .pkt_avail (pkt_avail),
        .pkt_len   (pkt_len),
        .free_req  (free_req)
    );

    usbtx_bank_ram #(.DATA_W(DATA_W), .DEPTH(BANK_BYTES)) ram_i (
        .clk     (clk),
        .we      (wr_fire),
        .wr_bank (wr_bank),
        .wr_addr (wr_fill[ADDR_W-1:0]),
        .wr_data (dma_wr_data),
        .rd_bank (rd_bank),
        .rd_addr (rd_ptr[ADDR_W-1:0]),
        .rd_data (rd_data)
    );

    assign wr_full = committed[wr_bank];
    assign dma_req = dma_en && !wr_full;

    // R11: after a clear the read side shows nothing and writing is open
    a_r11_clear_outputs: assert property (@(posedge clk) disable iff (rst)
        fifo_clr |=> (!pkt_avail && !wr_full));

    // R8: a write never lands while both banks wait to be sent
    a_r8_no_write_when_full: assert property (@(posedge clk) disable iff (rst)
        wr_full |-> !wr_fire);

endmodule

// File: tb/usb_in_pingpong_fifo_tb.sv
`timescale 1ns/1ps
module usb_in_pingpong_fifo_tb_top;

    localparam int DATA_W     = 8;
    localparam int BANK_BYTES = 64;
    localparam int CNT_W      = $clog2(BANK_BYTES + 1);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              fifo_clr = 1'b0;
    logic              dma_en = 1'b0;
    logic              dma_req;
    logic              dma_wr_valid = 1'b0;
    logic [DATA_W-1:0] dma_wr_data = '0;
    logic              pkt_en = 1'b0;
    logic              wr_full;
    logic              pkt_avail;
    logic [CNT_W-1:0]  pkt_len;
    logic              rd_en = 1'b0;
    logic [DATA_W-1:0] rd_data;
    logic              pkt_sent = 1'b0;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    usb_in_pingpong_fifo #(.DATA_W(DATA_W), .BANK_BYTES(BANK_BYTES)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .fifo_clr     (fifo_clr),
        .dma_en       (dma_en),
        .dma_req      (dma_req),
        .dma_wr_valid (dma_wr_valid),
        .dma_wr_data  (dma_wr_data),
        .pkt_en       (pkt_en),
        .wr_full      (wr_full),
        .pkt_avail    (pkt_avail),
        .pkt_len      (pkt_len),
        .rd_en        (rd_en),
        .rd_data      (rd_data),
        .pkt_sent     (pkt_sent)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one byte per cycle starting from a falling edge
    task automatic push_bytes(input int n, input int base, input bit strobe_last);
        for (int i = 0; i < n; i++) begin
            dma_wr_valid = 1'b1;
            dma_wr_data  = DATA_W'(base + i);
            pkt_en       = strobe_last && (i == n - 1);
            @(negedge clk);
        end
        dma_wr_valid = 1'b0;
        pkt_en       = 1'b0;
    endtask

    task automatic strobe_pkt_en();
        pkt_en = 1'b1;
        @(negedge clk);
        pkt_en = 1'b0;
    endtask

    task automatic drain_pkt(input string req, input int exp_len, input int base);
        chk({req, " avail"}, int'(pkt_avail), 1);
        chk({req, " len"}, int'(pkt_len), exp_len);
        for (int i = 0; i < exp_len; i++) begin
            chk({req, " data"}, int'(rd_data), (base + i) & 8'hFF);
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
        end
        pkt_sent = 1'b1;
        @(negedge clk);
        pkt_sent = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 avail", int'(pkt_avail), 0);
        chk("R1 full", int'(wr_full), 0);
        chk("R1 req off", int'(dma_req), 0);
        dma_en = 1'b1;
        #1;
        chk("R1 req follows", int'(dma_req), 1);
        @(negedge clk);
    endtask

    task automatic t_idle_request();
        for (int i = 0; i < 5; i++) begin
            chk("R6 idle req", int'(dma_req), 1);
            @(negedge clk);
        end
        dma_en = 1'b0;
        #1;
        chk("R7 req drop", int'(dma_req), 0);
        @(negedge clk);
        chk("R7 req stays low", int'(dma_req), 0);
        dma_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_full_packet();
        push_bytes(BANK_BYTES, 8'h10, 1'b0);
        chk("R2 len", int'(pkt_len), BANK_BYTES);
        chk("R2 other bank open", int'(wr_full), 0);
        chk("R6 req with space", int'(dma_req), 1);
        drain_pkt("R2 R9", BANK_BYTES, 8'h10);
        chk("R10 empty after send", int'(pkt_avail), 0);
        pkt_sent = 1'b1;
        @(negedge clk);
        pkt_sent = 1'b0;
        push_bytes(3, 8'h70, 1'b0);
        strobe_pkt_en();
        drain_pkt("R10 stray send ignored", 3, 8'h70);
    endtask

    task automatic t_150_bytes();
        push_bytes(2 * BANK_BYTES, 8'h20, 1'b0);
        chk("R8 full", int'(wr_full), 1);
        chk("R8 req low", int'(dma_req), 0);
        drain_pkt("R12 pkt1 R9", BANK_BYTES, 8'h20);
        chk("R10 next shown", int'(pkt_avail), 1);
        push_bytes(22, 8'h20 + 2 * BANK_BYTES, 1'b0);
        drain_pkt("R12 pkt2", BANK_BYTES, 8'h20 + BANK_BYTES);
        chk("R3 short not offered", int'(pkt_avail), 0);
        strobe_pkt_en();
        drain_pkt("R12 R3 pkt3", 22, 8'h20 + 2 * BANK_BYTES);
        chk("R12 all sent", int'(pkt_avail), 0);
    endtask

    task automatic t_zero_length();
        strobe_pkt_en();
        chk("R4 zlp avail", int'(pkt_avail), 1);
        chk("R4 zlp len", int'(pkt_len), 0);
        pkt_sent = 1'b1;
        @(negedge clk);
        pkt_sent = 1'b0;
        chk("R4 zlp freed", int'(pkt_avail), 0);
    endtask

    task automatic t_ignored_strobes();
        // strobe together with the filling write
        push_bytes(BANK_BYTES, 8'h40, 1'b1);
        drain_pkt("R5 coincident", BANK_BYTES, 8'h40);
        chk("R5 no extra pkt", int'(pkt_avail), 0);
        // strobe and write while both banks are committed
        push_bytes(2 * BANK_BYTES, 8'h80, 1'b0);
        strobe_pkt_en();
        push_bytes(1, 8'hEE, 1'b0);
        chk("R8 still full", int'(wr_full), 1);
        drain_pkt("R5 first", BANK_BYTES, 8'h80);
        drain_pkt("R5 second", BANK_BYTES, 8'h80 + BANK_BYTES);
        chk("R5 ignored strobe", int'(pkt_avail), 0);
        strobe_pkt_en();
        chk("R8 dropped byte", int'(pkt_len), 0);
        pkt_sent = 1'b1;
        @(negedge clk);
        pkt_sent = 1'b0;
    endtask

    task automatic t_clear();
        push_bytes(BANK_BYTES + 5, 8'h30, 1'b0);
        chk("R11 pre avail", int'(pkt_avail), 1);
        fifo_clr = 1'b1;
        @(negedge clk);
        fifo_clr = 1'b0;
        chk("R11 avail", int'(pkt_avail), 0);
        chk("R11 full", int'(wr_full), 0);
        push_bytes(4, 8'hC0, 1'b0);
        strobe_pkt_en();
        drain_pkt("R11 fresh", 4, 8'hC0);
        chk("R11 nothing left", int'(pkt_avail), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_idle_request();
        t_full_packet();
        t_150_bytes();
        t_zero_length();
        t_ignored_strobes();
        t_clear();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule